// File: doc/BRIEF.md
# Byte FIFO with Programmable Threshold Flag

A byte-wide synchronous FIFO built from a fixed number of equal-sized packet buffers. It drives two fixed status outputs, empty and full, and one programmable status output whose meaning is set by static configuration inputs. All three are active low. The read port runs in first-word-fall-through style: the oldest byte is always on `rd_data` while the FIFO holds data.

The programmable output compares a 9-bit threshold against one of two quantities. In byte mode the quantity is the total fill. In packet mode a packet counts as committed once its last byte is written. The flag then looks at how many committed packets remain unread and at the write offset inside the packet being filled. A direction input picks the comparison. With direction 1 the output is high when the quantity is at or above the threshold, which gives an almost-empty warning. With direction 0 it is high when the quantity is at or below the threshold, which gives an almost-full warning. For example, a threshold of 4 with direction 1 drives the output low while fewer than 4 bytes remain. A threshold of 508 with direction 0 in packet mode, with the packet limit one below the buffer count, drives it low when 3 byte slots are left.

Top module: `thresh_flag_fifo`

## Requirements
- R1: A synchronous reset empties the FIFO and clears the committed-packet count. On the cycle after reset, `empty_n` is 0 and `full_n` is 1.
- R2: Bytes leave in the order they were written. `rd_data` shows the oldest stored byte whenever `empty_n` is 1.
- R3: `empty_n` is 0 exactly when no byte is stored. `full_n` is 0 exactly when all NBUF*PKT_BYTES bytes are stored. The two are never 0 together.
- R4: A write while full changes nothing. A read while empty changes nothing.
- R5: The threshold is `{cfg_thr_hi, cfg_thr_lo}`, a 9-bit value whose top bit is `cfg_thr_hi`. In byte mode (`cfg_pkt_mode`=0) with `cfg_ge`=1, `prog_n` is 1 exactly when fill >= threshold.
- R6: In byte mode with `cfg_ge`=0, `prog_n` is 1 exactly when fill <= threshold.
- R7: A packet is committed when the write that fills its last byte (offset PKT_BYTES-1) is accepted. A packet leaves the committed count when its last byte is read. The current offset is the number of bytes written into the packet being filled.
- R8: In packet mode with `cfg_ge`=0, `prog_n` is 1 exactly when committed < `cfg_pkts`, or when committed = `cfg_pkts` and current offset <= threshold.
- R9: In packet mode with `cfg_ge`=1, `prog_n` is 1 exactly when committed > `cfg_pkts`, or when committed = `cfg_pkts` and current offset >= threshold.
- R10: A read and a write accepted in the same cycle leave the fill unchanged.
- R11: Every flag changes on the clock edge that accepts the write or read that changes the state behind it. Before that edge, the flag holds its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read request; pops the byte on `rd_data` |
| rd_data | output | 8 | Oldest stored byte |
| cfg_thr_lo | input | 8 | Threshold bits 7..0 |
| cfg_thr_hi | input | 1 | Threshold bit 8 |
| cfg_ge | input | 1 | Compare direction: 1 at-or-above, 0 at-or-below |
| cfg_pkt_mode | input | 1 | 1 selects the packet-aware compare |
| cfg_pkts | input | $clog2(NBUF+1) | Committed-packet count to match in packet mode |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| prog_n | output | 1 | Programmable flag (compare result) |

## Verification
The assertions assume that the configuration inputs stay constant while a compare result is being relied on. They also assume that reset is applied at start-up, before any request is made. The bench meets both conditions: it changes configuration only between stimulus steps, with no request active, and it holds reset through the first clock edges. Requests are driven one cycle at a time on the falling edge, so they do not change at the sampling edge. They include overflow and underflow attempts, which the assertions treat as legal requests that must have no effect.

// File: rtl/thresh_flag_fifo.sv
module thresh_flag_fifo #(
  parameter int PKT_BYTES = 512,
  parameter int NBUF      = 4,
  localparam int PCW      = $clog2(NBUF + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [7:0]     wr_data,
  input  logic           rd_en,
  output logic [7:0]     rd_data,
  input  logic [7:0]     cfg_thr_lo,
  input  logic           cfg_thr_hi,
  input  logic           cfg_ge,
  input  logic           cfg_pkt_mode,
  input  logic [PCW-1:0] cfg_pkts,
  output logic           empty_n,
  output logic           full_n,
  output logic           prog_n
);
  localparam int DEPTH = PKT_BYTES * NBUF;
  localparam int AW    = $clog2(DEPTH);
  localparam int PB    = $clog2(PKT_BYTES);
  localparam int FW    = $clog2(DEPTH + 1);
  localparam int CW    = (FW > 9) ? FW : 9;

  logic [7:0]     mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [FW-1:0]  fill;
  logic [PCW-1:0] pkts;

  wire is_full  = (fill == FW'(DEPTH));
  wire is_empty = (fill == '0);
  wire wr_ok    = wr_en && !is_full;
  wire rd_ok    = rd_en && !is_empty;
  wire [PB-1:0] wr_off = wr_ptr[PB-1:0];
  wire [PB-1:0] rd_off = rd_ptr[PB-1:0];
  wire wr_wrap  = wr_ok && (wr_off == {PB{1'b1}});
  wire rd_wrap  = rd_ok && (rd_off == {PB{1'b1}});

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_ptr] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      pkts   <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
      if (wr_ok && !rd_ok)      fill <= fill + 1'b1;
      else if (rd_ok && !wr_ok) fill <= fill - 1'b1;
      if (wr_wrap && !rd_wrap)      pkts <= pkts + 1'b1;
      else if (rd_wrap && !wr_wrap) pkts <= pkts - 1'b1;
    end
  end

  wire [CW-1:0] thr_x  = CW'({cfg_thr_hi, cfg_thr_lo});
  wire [CW-1:0] fill_x = CW'(fill);
  wire [CW-1:0] cur_x  = CW'(wr_off);

  wire byte_hit = cfg_ge ? (fill_x >= thr_x) : (fill_x <= thr_x);
  wire pkt_eq   = (pkts == cfg_pkts);
  wire pkt_hit  = cfg_ge ? ((pkts > cfg_pkts) || (pkt_eq && cur_x >= thr_x))
                         : ((pkts < cfg_pkts) || (pkt_eq && cur_x <= thr_x));

  assign rd_data = mem[rd_ptr];
  assign empty_n = !is_empty;
  assign full_n  = !is_full;
  assign prog_n  = cfg_pkt_mode ? pkt_hit : byte_hit;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!empty_n && full_n && pkts == '0));

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(!empty_n && !full_n));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    int'(fill) <= DEPTH);

  assert_full_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!full_n && wr_en && !rd_en) |=> (!full_n && $stable(wr_ptr) && $stable(rd_ptr)));

  assert_empty_read_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && rd_en && !wr_en) |=> (!empty_n && $stable(rd_ptr) && $stable(wr_ptr)));

  assert_pkt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    int'(pkts) <= NBUF);

  assert_pkt_fill_match_R7: assert property (@(posedge clk) disable iff (rst)
    int'(fill) == int'(pkts) * PKT_BYTES + int'(wr_off) - int'(rd_off));

  assert_both_keep_fill_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && empty_n && full_n) |=> $stable(fill));

  assert_write_sets_nonempty_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full_n && !rd_en) |=> empty_n);
endmodule

// File: tb/thresh_flag_fifo_test.sv
module thresh_flag_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int PKT   = 512;
  localparam int NB    = 4;
  localparam int DEPTH = PKT * NB;

  typedef struct packed {
    logic       pm;
    logic       ge;
    logic [8:0] thr;
    logic [2:0] pk;
    logic [1:0] op;
    logic [11:0] n;
    logic       e_empty;
    logic       e_full;
    logic       e_prog;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 9'd4,   3'd0, 2'd1, 12'd3,    1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b1, 9'd4,   3'd0, 2'd1, 12'd1,    1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 9'd4,   3'd0, 2'd2, 12'd1,    1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b0, 9'd508, 3'd0, 2'd1, 12'd505,  1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b0, 9'd508, 3'd0, 2'd1, 12'd1,    1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b0, 9'd509, 3'd0, 2'd0, 12'd0,    1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b0, 9'd508, 3'd3, 2'd0, 12'd0,    1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b0, 9'd508, 3'd3, 2'd1, 12'd2,    1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b0, 9'd508, 3'd3, 2'd1, 12'd1024, 1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b0, 9'd508, 3'd3, 2'd1, 12'd508,  1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b0, 9'd508, 3'd3, 2'd1, 12'd1,    1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b1, 9'd509, 3'd3, 2'd0, 12'd0,    1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b1, 9'd510, 3'd3, 2'd0, 12'd0,    1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0, 9'd508, 3'd3, 2'd1, 12'd3,    1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0, 9'd508, 3'd3, 2'd1, 12'd2,    1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 9'd508, 3'd3, 2'd2, 12'd511,  1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 9'd511, 3'd0, 2'd0, 12'd0,    1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 9'd511, 3'd0, 2'd2, 12'd1537, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 9'd0,   3'd0, 2'd0, 12'd0,    1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [8:0] thr = 9'd4;
  logic ge = 1'b1, pm = 1'b0;
  logic [2:0] pk = '0;
  logic empty_n, full_n, prog_n;

  int checks = 0, errors = 0;
  int wr_idx = 0, rd_idx = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  thresh_flag_fifo #(.PKT_BYTES(PKT), .NBUF(NB)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data),
    .cfg_thr_lo(thr[7:0]), .cfg_thr_hi(thr[8]), .cfg_ge(ge),
    .cfg_pkt_mode(pm), .cfg_pkts(pk),
    .empty_n(empty_n), .full_n(full_n), .prog_n(prog_n));

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = pat(wr_idx);
      if (wr_idx - rd_idx < DEPTH) wr_idx++;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_n(int n);
    bit bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wr_idx > rd_idx) begin
        if (rd_data !== pat(rd_idx) && !bad) begin
          bad = 1'b1;
          check("R2 order", int'(rd_data), int'(pat(rd_idx)));
        end
        rd_idx++;
      end
      rd_en = 1'b1;
    end
    @(negedge clk);
    rd_en = 1'b0;
    if (!bad) check("R2 order", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 empty_n after reset", int'(empty_n), 0);
    check("R1 full_n after reset", int'(full_n), 1);
    check("R5 prog_n after reset thr4 ge1", int'(prog_n), 0);

    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R4 read on empty keeps empty", int'(empty_n), 0);

    wr_en = 1'b1; wr_data = 8'hA5;
    check("R11 empty_n before write edge", int'(empty_n), 0);
    @(negedge clk); wr_en = 1'b0;
    check("R11 empty_n after write edge", int'(empty_n), 1);
    check("R2 fall-through data", int'(rd_data), 8'hA5);

    rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h3C;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    check("R10 simultaneous keeps nonempty", int'(empty_n), 1);
    check("R10 new head byte", int'(rd_data), 8'h3C);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R10 drained after one read", int'(empty_n), 0);

    write_n(5);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid-stream reset empties", int'(empty_n), 0);
    wr_idx = 0; rd_idx = 0;

    for (int v = 0; v < NV; v++) begin
      pm = VECS[v].pm; ge = VECS[v].ge; thr = VECS[v].thr; pk = VECS[v].pk;
      if (VECS[v].op == 2'd1) write_n(int'(VECS[v].n));
      else if (VECS[v].op == 2'd2) read_n(int'(VECS[v].n));
      else @(negedge clk);
      check($sformatf("R3 empty_n vec %0d", v), int'(empty_n), int'(VECS[v].e_empty));
      check($sformatf("R3 full_n vec %0d", v), int'(full_n), int'(VECS[v].e_full));
      check($sformatf("R5 R6 R7 R8 R9 prog_n vec %0d", v), int'(prog_n), int'(VECS[v].e_prog));
      if (v == 14) begin
        write_n(1);
        check("R4 write on full keeps full", int'(full_n), 0);
        check("R4 head unchanged by write on full", int'(rd_data), int'(pat(rd_idx)));
      end
    end

    pm = 1'b0; ge = 1'b0; thr = 9'd0;
    @(negedge clk);
    check("R6 fill 0 at or below thr 0", int'(prog_n), 1);
    write_n(1);
    check("R6 fill 1 above thr 0", int'(prog_n), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule